// File: doc/BRIEF.md
# Shared-Bus Multicycle Register Processor

This block is a compact 16-bit processor core. All data moves over one multiplexed bus, and each clock carries at most one transfer. The core has eight general registers, an instruction register, an operand register that feeds an adder/subtractor, and a result register that holds the unit's output. A hard-wired sequencer sets the bus source and the load enables in every clock.

A host presents a 16-bit instruction word and raises `run` while the core is idle. The core then executes the word. Register copy and immediate load each take one execute clock. Add and subtract take three execute clocks: operand capture, arithmetic, and write-back. `done` is high during the final execute clock of every instruction. The general registers and the bus value are visible at the ports, so a test harness can follow execution. The core has no program storage, program counter, branches or memory access.

Top module: `bus_proc16`

## Requirements
- R1: A synchronous active-low reset clears all eight registers to zero, holds `done` low, and leaves the core idle and ready to accept an instruction.
- R2: While idle with `run` low, the core ignores `instr_in`, keeps `done` low, and leaves every register unchanged.
- R3: The instruction encoding is: opcode in bits [15:13], destination register X in [12:10], source register Y in [9:7]. Opcode 000 copies register Y into register X. `done` is high in the first clock after the clock edge that sampled `run`, and X holds the new value after the next edge.
- R4: Opcode 001 loads register X with bits [9:0] sign-extended to 16 bits (bit 9 is the sign), with the same one-clock timing as R3.
- R5: Opcode 010 writes (X + Y) mod 2^16 into register X. It takes three execute clocks, and `done` is high in the third. The bus carries the value of X in the first clock and the value of Y in the second. When X and Y are the same register, the result is twice that register.
- R6: Opcode 011 follows the R5 sequence but writes (X − Y) mod 2^16.
- R7: No more than one general register loads in any clock. Every register other than the destination keeps its value.
- R8: `done` stays high for exactly one clock per instruction. The core then accepts the next instruction on the following `run`.
- R9: Opcodes 100 through 111 raise `done` after one execute clock and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start strobe, sampled while idle |
| instr_in | input | 16 | Instruction word, captured with `run` |
| done | output | 1 | High in the last execute clock of an instruction |
| bus_out | output | 16 | Current value on the shared bus |
| regs_flat | output | 128 | Registers 0..7, register i in bits [16*i+15:16*i] |

## Verification
A wrong sequencer state shows at the ports within one clock. `done` then rises too early or too late, and the bus value in the first or second execute clock of an add or subtract differs from the named operand. Any of these counts as an error. A wrong load enable or a stale operand or result register is found one clock after `done`, when the bench compares the whole register bank with its model. This catches both corrupted bystander registers and wrong arithmetic. Random instruction streams chain results through the registers, so a single bad write also spoils the checks that follow.

// File: rtl/bp_pkg.sv
// Shared types for the shared-bus processor.
// Assumes the opcode field is three bits wide.
package bp_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_EX1, ST_EX2, ST_EX3} state_t;
    typedef enum logic [1:0] {SRC_REG, SRC_IMM, SRC_RES} src_t;
    localparam logic [2:0] OP_MV  = 3'b000;
    localparam logic [2:0] OP_MVI = 3'b001;
    localparam logic [2:0] OP_ADD = 3'b010;
    localparam logic [2:0] OP_SUB = 3'b011;
endpackage

// File: rtl/bp_regfile.sv
// Bank of general registers. Each register has its own load enable and
// captures the bus on the rising edge while that enable is high.
// Assumes the controller raises at most one enable at a time.
module bp_regfile #(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   load_en,
    input  logic [W-1:0]      bus_in,
    output logic [NREG*W-1:0] q_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        // Hold or capture the bus value for register i
        always_ff @(posedge clk) begin
            if (!rst_n)          q <= '0;
            else if (load_en[i]) q <= bus_in;
        end
        assign q_flat[i*W +: W] = q;
    end
endmodule

// File: rtl/bp_bus_mux.sv
// Shared-bus source selector. The sources are one general register, the
// sign-extended immediate from the instruction, or the result register.
// Assumes IMMW < W.
module bp_bus_mux
    import bp_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8,
    parameter int IMMW = 10,
    localparam int RB  = $clog2(NREG)
) (
    input  src_t              src,
    input  logic [RB-1:0]     rsel,
    input  logic [NREG*W-1:0] q_flat,
    input  logic [W-1:0]      ir,
    input  logic [W-1:0]      res,
    output logic [W-1:0]      bus
);
    logic [W-1:0] imm_ext;
    assign imm_ext = {{(W-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};

    // Drive the bus from the selected source
    always_comb begin
        case (src)
            SRC_REG: bus = q_flat[rsel*W +: W];
            SRC_IMM: bus = imm_ext;
            default: bus = res;
        endcase
    end
endmodule

// File: rtl/bp_arith.sv
// Operand register, adder/subtractor and result register. The operand
// register captures the bus; the result register captures operand +/- bus.
// Assumes arithmetic wraps modulo 2^W.
module bp_arith #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         opnd_ld,
    input  logic         res_ld,
    input  logic         do_sub,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] res_q
);
    logic [W-1:0] opnd_q;
    logic [W-1:0] sum;

    assign sum = do_sub ? (opnd_q - bus_in) : (opnd_q + bus_in);

    // Capture the first operand from the bus
    always_ff @(posedge clk) begin
        if (!rst_n)       opnd_q <= '0;
        else if (opnd_ld) opnd_q <= bus_in;
    end

    // Capture the arithmetic result
    always_ff @(posedge clk) begin
        if (!rst_n)      res_q <= '0;
        else if (res_ld) res_q <= sum;
    end
endmodule

// File: rtl/bp_ctrl.sv
// Hard-wired sequencer with the instruction register. It loads the
// instruction while idle and run is high, then steps through up to three
// execute states. It decodes the bus source and the load enables from the
// state and the instruction fields.
// Assumes the opcode is the top three bits, followed by X and then Y.
module bp_ctrl
    import bp_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8,
    localparam int RB  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [W-1:0]    instr_in,
    output logic [W-1:0]    ir,
    output state_t          state,
    output src_t            src,
    output logic [RB-1:0]   rsel,
    output logic [NREG-1:0] load_en,
    output logic            opnd_ld,
    output logic            res_ld,
    output logic            do_sub,
    output logic            done
);
    localparam int OP_HI = W - 1;
    localparam int X_HI  = W - 4;
    localparam int Y_HI  = W - 4 - RB;

    state_t        nxt;
    logic [2:0]    opc;
    logic [RB-1:0] rx, ry;

    assign opc = ir[OP_HI -: 3];
    assign rx  = ir[X_HI -: RB];
    assign ry  = ir[Y_HI -: RB];

    // Capture a new instruction when idle and started
    always_ff @(posedge clk) begin
        if (!rst_n)                       ir <= '0;
        else if (state == ST_IDLE && run) ir <= instr_in;
    end

    // Advance the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Decode the next state and the datapath controls
    always_comb begin
        nxt     = state;
        src     = SRC_RES;
        rsel    = ry;
        load_en = '0;
        opnd_ld = 1'b0;
        res_ld  = 1'b0;
        do_sub  = 1'b0;
        done    = 1'b0;
        case (state)
            ST_IDLE: if (run) nxt = ST_EX1;
            ST_EX1: begin
                case (opc)
                    OP_MV: begin
                        src         = SRC_REG;
                        load_en[rx] = 1'b1;
                        done        = 1'b1;
                        nxt         = ST_IDLE;
                    end
                    OP_MVI: begin
                        src         = SRC_IMM;
                        load_en[rx] = 1'b1;
                        done        = 1'b1;
                        nxt         = ST_IDLE;
                    end
                    OP_ADD, OP_SUB: begin
                        src     = SRC_REG;
                        rsel    = rx;
                        opnd_ld = 1'b1;
                        nxt     = ST_EX2;
                    end
                    default: begin
                        done = 1'b1;
                        nxt  = ST_IDLE;
                    end
                endcase
            end
            ST_EX2: begin
                src    = SRC_REG;
                res_ld = 1'b1;
                do_sub = (opc == OP_SUB);
                nxt    = ST_EX3;
            end
            default: begin
                src         = SRC_RES;
                load_en[rx] = 1'b1;
                done        = 1'b1;
                nxt         = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/bus_proc16.sv
// Top level of the shared-bus multicycle processor. It joins the sequencer,
// the register bank, the bus selector and the arithmetic registers.
// Assumes one bus transfer per clock; the bus and the registers are exposed.
module bus_proc16
    import bp_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [W-1:0]      instr_in,
    output logic              done,
    output logic [W-1:0]      bus_out,
    output logic [NREG*W-1:0] regs_flat
);
    localparam int RB   = $clog2(NREG);
    localparam int IMMW = W - 3 - RB;

    logic [W-1:0]    ir;
    state_t          st;
    src_t            src;
    logic [RB-1:0]   rsel;
    logic [NREG-1:0] reg_en;
    logic            opnd_ld, res_ld, do_sub;
    logic [W-1:0]    res_q;

    bp_ctrl #(.W(W), .NREG(NREG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .instr_in(instr_in),
        .ir(ir), .state(st), .src(src), .rsel(rsel), .load_en(reg_en),
        .opnd_ld(opnd_ld), .res_ld(res_ld), .do_sub(do_sub), .done(done)
    );

    bp_regfile #(.W(W), .NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .load_en(reg_en), .bus_in(bus_out),
        .q_flat(regs_flat)
    );

    bp_bus_mux #(.W(W), .NREG(NREG), .IMMW(IMMW)) u_mux (
        .src(src), .rsel(rsel), .q_flat(regs_flat), .ir(ir), .res(res_q),
        .bus(bus_out)
    );

    bp_arith #(.W(W)) u_arith (
        .clk(clk), .rst_n(rst_n), .opnd_ld(opnd_ld), .res_ld(res_ld),
        .do_sub(do_sub), .bus_in(bus_out), .res_q(res_q)
    );
endmodule

// File: rtl/bp_check.sv
// Protocol checker bound to the processor top. It watches the sequencer
// state, the load enables, the bus and the result register.
// Assumes reset is applied before the first checked edge.
module bp_check
    import bp_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              done,
    input  state_t            state,
    input  logic [NREG-1:0]   reg_en,
    input  logic [2:0]        opc,
    input  logic [NREG*W-1:0] regs,
    input  logic [W-1:0]      bus,
    input  logic [W-1:0]      res
);
    a_r7_one_load: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_en));

    a_r2_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(|reg_en) |=> $stable(regs));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && run) |=> state == ST_EX1);

    a_r5_steps: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EX2 |=> state == ST_EX3);

    a_r5_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EX3 |-> (bus == res && done));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && state == ST_IDLE));

    a_r9_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && opc[2]) |-> reg_en == '0);
endmodule

bind bus_proc16 bp_check #(.W(W), .NREG(NREG)) u_check (
    .clk(clk), .rst_n(rst_n), .run(run), .done(done), .state(st),
    .reg_en(reg_en), .opc(ir[W-1 -: 3]), .regs(regs_flat), .bus(bus_out),
    .res(res_q)
);

// File: tb/tb_bus_proc16.sv
// Self-checking bench: directed corner cases plus a seeded random stream,
// compared against a register model kept in the bench.
module tb_bus_proc16;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b0;
    logic [15:0]  instr_in = '0;
    logic         done;
    logic [15:0]  bus_out;
    logic [127:0] regs_flat;

    int errors = 0;
    int checks = 0;
    logic [15:0] m [8];

    bus_proc16 dut (.clk(clk), .rst_n(rst_n), .run(run), .instr_in(instr_in),
                    .done(done), .bus_out(bus_out), .regs_flat(regs_flat));

    always #5 clk = ~clk;

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] x,
                                       input logic [2:0] y);
        return {op, x, y, 7'd0};
    endfunction

    function automatic logic [15:0] enc_imm(input logic [2:0] x, input logic [9:0] d);
        return {3'b001, x, d};
    endfunction

    function automatic logic [15:0] sext10(input logic [9:0] d);
        return {{6{d[9]}}, d};
    endfunction

    function automatic int exp_lat(input logic [2:0] op);
        return (op == 3'b010 || op == 3'b011) ? 3 : 1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int i = 0; i < 8; i++) f[i*16 +: 16] = m[i];
        return f;
    endfunction

    // Issue one instruction, check latency, bus operands and final registers
    task automatic exec(input logic [15:0] ins, input string req);
        logic [2:0] op = ins[15:13];
        logic [2:0] x = ins[12:10];
        logic [2:0] y = ins[9:7];
        logic [15:0] b1, b2;
        int lat;
        @(negedge clk);
        run = 1'b1;
        instr_in = ins;
        @(negedge clk);
        run = 1'b0;
        instr_in = $urandom;
        lat = 1;
        b1 = bus_out;
        b2 = '0;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
            if (lat == 2) b2 = bus_out;
        end
        check(lat == exp_lat(op), {req, " latency"}, lat, exp_lat(op));
        if (exp_lat(op) == 3) begin
            check(b1 == m[x] && b2 == m[y], {req, " bus operands"},
                  {b1, b2}, {m[x], m[y]});
        end
        case (op)
            3'b000: m[x] = m[y];
            3'b001: m[x] = sext10(ins[9:0]);
            3'b010: m[x] = m[x] + m[y];
            3'b011: m[x] = m[x] - m[y];
            default: ;
        endcase
        @(negedge clk);
        check(!done, {req, " R8 done single pulse"}, done, 0);
        check(regs_flat == model_flat(), {req, " R7 register bank"},
              regs_flat, model_flat());
    endtask

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(regs_flat == '0 && !done, "R1 reset", {done, regs_flat}, 0);

        // R2: idle with run low ignores input
        for (int k = 0; k < 6; k++) begin
            instr_in = $urandom;
            @(negedge clk);
            check(!done && regs_flat == model_flat(), "R2 idle", regs_flat, model_flat());
        end

        // R4: sign extension boundaries
        exec(enc_imm(3'd1, 10'h1FF), "R4 max positive");
        exec(enc_imm(3'd2, 10'h200), "R4 min negative");
        exec(enc_imm(3'd3, 10'h3FF), "R4 minus one");
        // R3: copy, including self-copy
        exec(enc(3'b000, 3'd4, 3'd2), "R3 copy");
        exec(enc(3'b000, 3'd4, 3'd4), "R3 self copy");
        // R5: add, wrap and same register
        exec(enc(3'b010, 3'd1, 3'd1), "R5 double");
        exec(enc(3'b010, 3'd3, 3'd2), "R5 add negative");
        exec(enc(3'b010, 3'd3, 3'd3), "R5 wrap");
        // R6: subtract below zero and self
        exec(enc(3'b011, 3'd0, 3'd1), "R6 negative result");
        exec(enc(3'b011, 3'd5, 3'd5), "R6 self zero");
        // R9: all undefined opcodes
        for (int op = 4; op < 8; op++)
            exec(enc(op[2:0], 3'd1, 3'd2), "R9 undefined");

        // Random stream across all opcodes (R3 R4 R5 R6 R7 R9)
        for (int n = 0; n < 300; n++) begin
            logic [15:0] w = $urandom;
            if (w[15:13] > 3'b011 && ($urandom % 4) != 0) w[15] = 1'b0;
            exec(w, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule